// File: doc/BRIEF.md
# Credit-Tracked Packet Mailbox FIFO Controller

This controller manages a receive mailbox that lives in an external single-port word memory. Words arrive from one of two write sources. The first is a bus-style port with an address phase followed by a data phase. The second is a streaming port that takes one word per cycle. Stored words leave through a CPU-side pop port, first in, first out, with circular read and write pointers.

The word stream is split into packets. The first word of each packet is a length, and it says how many words follow. When the last word of a packet has been stored, a one-cycle commit interrupt is raised.

The block also tracks how many words the remote sender may still send. Every word read out frees a credit. Freed credits are collected and handed out as a delta on a valid/ready output once a programmable threshold is met. Writing to a full store or reading from an empty one does not fail the transfer. Each is recorded in a sticky flag instead.

Top module: `mbox_credit_fifo`

## Requirements
- R1: After reset, `credits` equals DEPTH, `rel_valid`, `pkt_irq`, `overrun` and `underrun` are 0, and `ahb_ready` is 1.
- R2: Stored words are popped in the order they were stored, whichever port they came from. A pop accepted at a clock edge (`rd_req` and `rd_ready` both high) gives `rd_valid` high with the word on `rd_data` in the following cycle.
- R3: `credits` always equals DEPTH minus the number of stored words. It falls by one for each stored write and rises by one for each successful pop, and it never exceeds DEPTH.
- R4: The first stored word of a packet carries the count L of words that follow in bits [CW-1:0], where CW = log2(DEPTH)+1. `pkt_irq` is high for exactly one cycle, right after the edge that stores the packet's last word. When L=0, that last word is the length word itself.
- R5: If the streaming port is valid during a bus data phase, the streaming word is stored first and `ahb_ready` is held low for that cycle. The bus word is stored at the next edge with no streaming word present.
- R6: The memory has a single port, so a pop is accepted only when no write is presented. `rd_ready` is low while `st_valid` is high or a bus data phase is pending.
- R7: Each successful pop adds one to an accumulator. Once the accumulator reaches the threshold, the next cycle presents `rel_valid` with `rel_delta` equal to the accumulated count, and the accumulator restarts. A threshold of 0 behaves as 1, so each freed credit goes out on its own.
- R8: While `rel_ready` is low, `rel_valid` stays high and `rel_delta` stays unchanged.
- R9: A write while the store is full is dropped. It leaves the contents, `credits` and packet framing untouched, sets `overrun`, which then stays set, and still completes with `ahb_ready` high.
- R10: A pop from an empty store returns `rd_data` = 0 and leaves `credits` unchanged. It sets `underrun`, which then stays set.
- R11: A one-cycle `flush` empties the store (`credits` back to DEPTH), clears the partial-packet count so the next word is read as a length, and clears the credit accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty the store and restart framing and accumulation |
| rel_thresh | input | CW | Credit release threshold |
| ahb_sel | input | 1 | Bus write address phase valid |
| ahb_wdata | input | DW | Bus write data (data phase) |
| ahb_ready | output | 1 | Bus transfer ready / data phase completes |
| st_valid | input | 1 | Streaming word valid |
| st_data | input | DW | Streaming word |
| rd_req | input | 1 | Pop request |
| rd_ready | output | 1 | Pop can be accepted this cycle |
| rd_valid | output | 1 | Popped word present |
| rd_data | output | DW | Popped word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |
| credits | output | CW | Free word slots |
| pkt_irq | output | 1 | Packet committed pulse |
| rel_valid | output | 1 | Credit delta valid |
| rel_ready | input | 1 | Credit delta taken |
| rel_delta | output | CW | Credit delta value |
| overrun | output | 1 | Sticky write-while-full flag |
| underrun | output | 1 | Sticky read-while-empty flag |

## Verification
The properties assume a memory that returns the addressed word one cycle after a read. They also assume that `flush` is not asserted in the same cycle as a write or pop that matters. The bench meets both: its memory model has exactly that latency, and flushes are issued only while the ports are idle.

The properties also assume the bus master holds its data word while `ahb_ready` is low. The bench keeps `ahb_wdata` fixed through the stalled cycle of the collision case. It issues pops only when no write is driven, and it spaces operations so that a pending credit delta is always taken before the next one could form.

// File: rtl/mbox_credit_fifo.sv
module mbox_credit_fifo #(
  parameter int DEPTH = 4096,
  parameter int DW = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] rel_thresh,
  input  logic          ahb_sel,
  input  logic [DW-1:0] ahb_wdata,
  output logic          ahb_ready,
  input  logic          st_valid,
  input  logic [DW-1:0] st_data,
  input  logic          rd_req,
  output logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [CW-1:0] credits,
  output logic          pkt_irq,
  output logic          rel_valid,
  input  logic          rel_ready,
  output logic [CW-1:0] rel_delta,
  output logic          overrun,
  output logic          underrun
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] used, remain, acc;
  logic          ahb_dp, rd_zero;

  wire full   = (used == FULL);
  wire empty  = (used == '0);
  wire w_fire = st_valid | ahb_dp;
  wire [DW-1:0] w_data = st_valid ? st_data : ahb_wdata;
  wire w_ok   = w_fire & ~full;
  wire r_fire = rd_req & rd_ready;
  wire r_ok   = r_fire & ~empty;
  wire [CW-1:0] len = w_data[CW-1:0];
  wire [CW-1:0] thr = (rel_thresh == '0) ? CW'(1) : rel_thresh;
  wire xfer   = (acc >= thr) & ~(rel_valid & ~rel_ready);
  wire last   = (remain == '0) ? (len == '0) : (remain == CW'(1));

  assign ahb_ready = ~(ahb_dp & st_valid);
  assign rd_ready  = ~w_fire;
  assign rd_data   = rd_zero ? '0 : mem_rdata;
  assign mem_en    = w_ok | r_ok;
  assign mem_we    = w_ok;
  assign mem_addr  = w_ok ? wptr : rptr;
  assign mem_wdata = w_data;
  assign credits   = FULL - used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahb_dp <= 1'b0;
      rd_valid <= 1'b0;
      rd_zero <= 1'b0;
      overrun <= 1'b0;
      underrun <= 1'b0;
      rel_valid <= 1'b0;
      rel_delta <= '0;
    end else begin
      if (ahb_ready) ahb_dp <= ahb_sel;
      rd_valid <= r_fire;
      rd_zero <= ~r_ok;
      if (w_fire & full) overrun <= 1'b1;
      if (r_fire & empty) underrun <= 1'b1;
      if (rel_valid & rel_ready) rel_valid <= 1'b0;
      if (xfer & ~flush) begin
        rel_valid <= 1'b1;
        rel_delta <= acc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      used <= '0;
      remain <= '0;
      acc <= '0;
      pkt_irq <= 1'b0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      used <= '0;
      remain <= '0;
      acc <= '0;
      pkt_irq <= 1'b0;
    end else begin
      pkt_irq <= w_ok & last;
      if (w_ok) begin
        wptr <= wptr + 1'b1;
        used <= used + 1'b1;
        remain <= (remain == '0) ? len : remain - 1'b1;
      end
      if (r_ok) begin
        rptr <= rptr + 1'b1;
        used <= used - 1'b1;
      end
      acc <= (xfer ? '0 : acc) + CW'(r_ok);
    end
  end
endmodule

// File: rtl/mbox_credit_fifo_chk.sv
module mbox_credit_fifo_chk #(
  parameter int DEPTH = 4096,
  parameter int DW = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          ahb_ready,
  input logic          st_valid,
  input logic          rd_req,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          mem_en,
  input logic          mem_we,
  input logic [CW-1:0] credits,
  input logic          pkt_irq,
  input logic          rel_valid,
  input logic          rel_ready,
  input logic [CW-1:0] rel_delta,
  input logic          overrun,
  input logic          underrun
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) credits <= FULL); // R3
  AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (credits == $past(credits) || credits == $past(credits) + 1'b1 || credits == $past(credits) - 1'b1)); // R3
  AST_IRQ_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && !(mem_en && mem_we) |=> !pkt_irq); // R4
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) !ahb_ready |-> st_valid); // R5
  AST_READ_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) mem_en && !mem_we |-> rd_req && !st_valid); // R6
  AST_DELTA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) rel_valid |-> rel_delta != '0); // R7
  AST_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !rel_ready |=> rel_valid && $stable(rel_delta)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R9
  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) underrun |=> underrun); // R10
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && credits == FULL && !st_valid && ahb_ready |=> rd_valid && rd_data == '0); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> credits == FULL); // R11
endmodule

bind mbox_credit_fifo mbox_credit_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ahb_ready(ahb_ready), .st_valid(st_valid),
  .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .mem_en(mem_en), .mem_we(mem_we),
  .credits(credits), .pkt_irq(pkt_irq), .rel_valid(rel_valid), .rel_ready(rel_ready),
  .rel_delta(rel_delta), .overrun(overrun), .underrun(underrun)
);

// File: tb/sim_mbox_credit_fifo.sv
`timescale 1ns/1ps
module sim_mbox_credit_fifo;
  localparam int D = 16;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [CW-1:0] rel_thresh = '0;
  logic ahb_sel = 0, st_valid = 0, rd_req = 0, rel_ready = 1;
  logic [31:0] ahb_wdata = '0, st_data = '0, mem_rdata;
  logic ahb_ready, rd_ready, rd_valid, mem_en, mem_we, pkt_irq, rel_valid, overrun, underrun;
  logic [31:0] rd_data, mem_wdata;
  logic [3:0] mem_addr;
  logic [CW-1:0] credits, rel_delta;

  mbox_credit_fifo #(.DEPTH(D), .DW(32)) u0 (.*);

  always #2 clk = ~clk;

  logic [31:0] mem [0:D-1];
  logic [31:0] rdq;
  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else rdq <= mem[mem_addr];
    end
  end
  assign mem_rdata = rdq;

  int checks = 0, errors = 0;
  int rem = 0, acc = 0, exp_irq = 0, irq_cnt = 0;
  logic [31:0] mq[$];
  logic [31:0] exp_rd[$];
  int exp_rel[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rd_valid) begin
      if (exp_rd.size() == 0) chk("R2 unexpected pop", 1, 0);
      else chk("R2 pop data", rd_data, exp_rd.pop_front());
    end
    if (rel_valid && rel_ready) begin
      if (exp_rel.size() == 0) chk("R7 unexpected delta", 1, 0);
      else chk("R7 delta", 32'(rel_delta), 32'(exp_rel.pop_front()));
    end
    if (pkt_irq) irq_cnt++;
  end

  function automatic void m_write(logic [31:0] d);
    if (mq.size() < D) begin
      mq.push_back(d);
      if (rem == 0) begin
        rem = int'(d[CW-1:0]);
        if (rem == 0) exp_irq++;
      end else begin
        rem--;
        if (rem == 0) exp_irq++;
      end
    end
  endfunction

  task automatic st_write(logic [31:0] d);
    @(posedge clk); #1 st_valid = 1; st_data = d;
    @(posedge clk); #1 st_valid = 0;
    m_write(d);
  endtask

  task automatic ahb_write(logic [31:0] d);
    @(posedge clk); #1 ahb_sel = 1;
    @(posedge clk); #1 ahb_sel = 0; ahb_wdata = d;
    @(posedge clk); #1;
    m_write(d);
  endtask

  task automatic pop();
    int th;
    @(posedge clk); #1 rd_req = 1;
    @(posedge clk); #1 rd_req = 0;
    if (mq.size() > 0) begin
      exp_rd.push_back(mq.pop_front());
      acc++;
      th = (rel_thresh == 0) ? 1 : int'(rel_thresh);
      if (acc >= th) begin exp_rel.push_back(acc); acc = 0; end
    end else exp_rd.push_back(32'h0);
  endtask

  task automatic do_flush();
    @(posedge clk); #1 flush = 1;
    @(posedge clk); #1 flush = 0;
    mq.delete(); rem = 0; acc = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 credits", 32'(credits), D);
    chk("R1 flags", {rel_valid, pkt_irq, overrun, underrun}, 0);
    chk("R1 ahb_ready", 32'(ahb_ready), 1);

    st_write(3); st_write(32'hA1); st_write(32'hA2); st_write(32'hA3);
    idle(1);
    chk("R3 credits after stream packet", 32'(credits), D - 4);
    chk("R4 commit count", irq_cnt, exp_irq);

    ahb_write(1); ahb_write(32'hB1);
    idle(1);
    chk("R4 commit count bus packet", irq_cnt, exp_irq);
    chk("R3 credits after bus packet", 32'(credits), D - 6);

    @(posedge clk); #1 ahb_sel = 1;
    @(posedge clk); #1 ahb_sel = 0; ahb_wdata = 32'hC2; st_valid = 1; st_data = 32'h1;
    @(negedge clk);
    chk("R5 bus stalled on collision", 32'(ahb_ready), 0);
    chk("R6 pop blocked during write", 32'(rd_ready), 0);
    @(posedge clk); #1 st_valid = 0;
    @(posedge clk); #1;
    m_write(32'h1); m_write(32'hC2);
    idle(1);
    chk("R5 both words stored", 32'(credits), D - 8);
    chk("R4 commit after collision", irq_cnt, exp_irq);

    repeat (8) pop();
    idle(2);
    chk("R3 credits after drain", 32'(credits), D);

    pop();
    idle(1);
    chk("R10 underrun flag", 32'(underrun), 1);
    chk("R10 credits unchanged", 32'(credits), D);

    rel_thresh = 3;
    st_write(4); repeat (4) st_write(32'hD0);
    repeat (5) pop();
    st_write(5); st_write(32'hE1); st_write(32'hE2);
    do_flush();
    idle(1);
    chk("R11 credits after flush", 32'(credits), D);
    st_write(0);
    idle(1);
    chk("R11 framing restarts", irq_cnt, exp_irq);
    pop();
    idle(3);
    chk("R11 accumulator cleared", exp_rel.size(), 0);
    chk("R11 no delta pending", 32'(rel_valid), 0);

    rel_thresh = 15;
    st_write(15);
    for (int i = 0; i < 15; i++) st_write(32'h100 + 32'(i));
    idle(1);
    chk("R9 store full", 32'(credits), 0);
    st_write(2);
    @(posedge clk); #1 ahb_sel = 1;
    @(posedge clk); #1 ahb_sel = 0; ahb_wdata = 32'h2;
    @(negedge clk);
    chk("R9 bus write completes when full", 32'(ahb_ready), 1);
    @(posedge clk); #1;
    m_write(32'h2);
    idle(1);
    chk("R9 overrun flag", 32'(overrun), 1);
    chk("R9 credits unchanged", 32'(credits), 0);
    repeat (16) pop();
    st_write(0);
    idle(1);
    chk("R9 dropped word ignored by framing", irq_cnt, exp_irq);

    do_flush();
    st_write(7);
    rel_thresh = 1;
    rel_ready = 0;
    pop();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 delta held", 32'(rel_valid), 1);
    chk("R8 delta value", 32'(rel_delta), 1);
    @(posedge clk); #1 rel_ready = 1;
    idle(3);
    chk("R7 all deltas seen", exp_rel.size(), 0);
    chk("R2 all pops seen", exp_rd.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule